// File: doc/BRIEF.md
# Periodic and Event Interrupt Controller

This block turns a 32.768 kHz time-base strobe into a programmable periodic event. It gathers that event, together with alarm and update-ended pulses supplied by the calendar logic outside the block, into three sticky flag bits. Each flag is masked by its own enable bit, and the masked result drives one active-high interrupt request line. A host reads the flag register to find the cause. The read returns the flags and clears them, which releases the request. A square-wave output can optionally follow the selected periodic rate.

The host reaches four byte-wide registers through a plain strobe interface: a rate register, a control register, a flag register and a supply-status register. Address decoding on the host bus happens outside the block. The time-base strobe `tick_32k` is a one-cycle enable in the system clock domain, high once per 32.768 kHz period.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After a synchronous reset, the rate register reads 0x26, the control register reads 0x00 and the flag register reads 0x00. `irq_req` and `sqw_out` are low.
- R2: `reg_addr` selects the registers as follows: 0 is rate, 1 is control, 2 is flags, 3 is supply. Rate bits 6..0 are writable and bit 7 reads 0. All 8 control bits read back as written. Writes to addresses 2 and 3 have no effect. `rd_data` is loaded on the clock edge where `rd_stb` is high and holds its value until the next read.
- R3: Rate bits 3..0 hold a code that sets the periodic period, measured in time-base ticks. Code 1 gives 128 ticks and code 2 gives 256 ticks. A code c from 3 to 15 gives 2^(c-1) ticks. Code 0 produces no periodic events.
- R4: The tick divider runs only while rate bits 6..4 equal 010. For any other value, the divider is held at zero and no periodic event occurs. After the divider is enabled, the first periodic event arrives on exactly the period-th tick.
- R5: Flag bit 6 (periodic), bit 5 (alarm) and bit 4 (update-ended) are set by their events whatever the enables hold. Flag bits 3..0 always read 0.
- R6: Control bits 6, 5 and 4 enable the periodic, alarm and update-ended flags. Flag bit 7 and `irq_req` are high whenever any flag is set together with its enable. Setting an enable while its flag is already set raises the request.
- R7: A read of the flag register returns the pre-read value and clears all flags, so `irq_req` drops. An event that arrives in the same cycle as the read is not returned, and it remains set for the next read.
- R8: The supply register reads `supply_ok` in bit 7, sampled at the read, with bits 6..0 equal to 0.
- R9: With control bit 3 set, a non-zero code and the divider running, `sqw_out` is a 50% square wave whose period equals the periodic period. Its falling edge lands in the same cycle as the periodic flag is set. `sqw_out` is low whenever control bit 3 is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_32k | input | 1 | One-cycle strobe at the 32.768 kHz rate |
| alarm_in | input | 1 | Alarm event pulse from calendar logic |
| update_in | input | 1 | Update-ended event pulse from calendar logic |
| supply_ok | input | 1 | Backup supply valid indication |
| reg_addr | input | 2 | Register select |
| wr_stb | input | 1 | Write strobe |
| rd_stb | input | 1 | Read strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| irq_req | output | 1 | Active-high interrupt request |
| sqw_out | output | 1 | Square-wave output |

## Verification
The hardest points to reach from the ports are the exact tick on which a periodic event fires, for every one of the fifteen codes, and the square-wave edges around it. The divider runs freely, so its phase cannot be seen. The stimulus therefore first parks the divider by writing a time-base field other than 010. It then re-enables the divider with the code under test and the tick held high. Counting from that write fixes the expected cycles of the request and of both square-wave edges arithmetically, and the sweep covers all codes up to the 16384-tick period. The read-versus-event collision is produced by raising an event pulse in the same cycle as a flag read.

// File: rtl/eic_pkg.sv
// Shared definitions for the periodic and event interrupt controller.
// Assumes an 8-bit register interface with four registers.
package eic_pkg;

    typedef enum logic [1:0] {
        SEL_RATE   = 2'd0,
        SEL_CTRL   = 2'd1,
        SEL_FLAG   = 2'd2,
        SEL_SUPPLY = 2'd3
    } reg_sel_e;

    localparam logic [2:0] TB_RUN     = 3'b010;
    localparam logic [6:0] RATE_RESET = 7'h26;
    localparam logic [7:0] CTRL_RESET = 8'h00;
    localparam int         NUM_EVT    = 3;

    // Event bit positions inside the 3-bit flag and enable vectors.
    localparam int EV_PER = 2;
    localparam int EV_ALM = 1;
    localparam int EV_UPD = 0;

    // Periodic period exponent (period = 2**shift ticks); 0 means off.
    function automatic logic [4:0] rate_shift(input logic [3:0] code);
        logic [4:0] s;
        case (code)
            4'd0:    s = 5'd0;
            4'd1:    s = 5'd7;
            4'd2:    s = 5'd8;
            default: s = {1'b0, code} - 5'd1;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/eic_rate_div.sv
// Tick divider: counts time-base strobes, emits one periodic event per
// 2**shift ticks and derives the square wave from the counter.
// Assumes CNT_W >= 14 so that the longest period (code 15) fits.
module eic_rate_div
    import eic_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [2:0] tb_sel,
    input  logic [3:0] rate_code,
    input  logic       sqw_en,
    output logic       periodic_evt,
    output logic       sqw
);

    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] low_mask;
    logic [4:0]       shift;
    logic             running;
    logic             half_bit;

    assign running = (tb_sel == TB_RUN);
    assign shift   = rate_shift(rate_code);

    // Build the mask of counter bits that make up one period.
    always_comb begin
        for (int i = 0; i < CNT_W; i++) begin
            low_mask[i] = (5'(i) < shift);
        end
    end

    // Pick the top counter bit of the period as the square-wave phase.
    always_comb begin
        half_bit = 1'b0;
        for (int i = 0; i < CNT_W; i++) begin
            if ((shift != 5'd0) && (5'(i) == shift - 5'd1)) begin
                half_bit = cnt_q[i];
            end
        end
    end

    // Advance on each tick while the time base runs; park at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!running) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + CNT_ONE;
        end
    end

    assign periodic_evt = tick && running && (shift != 5'd0)
                          && ((cnt_q & low_mask) == low_mask);
    assign sqw          = sqw_en && running && (shift != 5'd0) && half_bit;

endmodule

// File: rtl/eic_flag_unit.sv
// Sticky event flags with clear-on-read and the masked request line.
// Assumes the clear strobe is one cycle; a same-cycle event wins.
module eic_flag_unit
    import eic_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic               clr,
    input  logic [NUM_EVT-1:0] en,
    output logic [NUM_EVT-1:0] flags_q,
    output logic               irq
);

    // Capture events; a read clears older flags but keeps new ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= (clr ? '0 : flags_q) | evt_in;
        end
    end

    assign irq = |(flags_q & en);

endmodule

// File: rtl/eic_regs.sv
// Host register file: rate and control storage, read mux with a
// registered output, and the flag-clear strobe.
// Assumes at most one of wr_stb/rd_stb per cycle is meaningful.
module eic_regs
    import eic_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         reg_addr,
    input  logic               wr_stb,
    input  logic               rd_stb,
    input  logic [7:0]         wr_data,
    input  logic [NUM_EVT-1:0] flags,
    input  logic               irq,
    input  logic               supply_ok,
    output logic [2:0]         tb_sel,
    output logic [3:0]         rate_code,
    output logic [NUM_EVT-1:0] irq_en,
    output logic               sqw_en,
    output logic               flag_clr,
    output logic [7:0]         rd_data
);

    logic [6:0] rate_q;
    logic [7:0] ctrl_q;
    logic [7:0] rd_mux;

    // Store host writes into the two writable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q <= RATE_RESET;
            ctrl_q <= CTRL_RESET;
        end else if (wr_stb) begin
            case (reg_sel_e'(reg_addr))
                SEL_RATE: rate_q <= wr_data[6:0];
                SEL_CTRL: ctrl_q <= wr_data;
                default:  ;
            endcase
        end
    end

    // Select the byte presented for the addressed register.
    always_comb begin
        case (reg_sel_e'(reg_addr))
            SEL_RATE: rd_mux = {1'b0, rate_q};
            SEL_CTRL: rd_mux = ctrl_q;
            SEL_FLAG: rd_mux = {irq, flags, 4'b0000};
            default:  rd_mux = {supply_ok, 7'b0000000};
        endcase
    end

    // Hold read data between read strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= 8'h00;
        end else if (rd_stb) begin
            rd_data <= rd_mux;
        end
    end

    assign flag_clr  = rd_stb && (reg_sel_e'(reg_addr) == SEL_FLAG);
    assign tb_sel    = rate_q[6:4];
    assign rate_code = rate_q[3:0];
    assign irq_en    = ctrl_q[6:4];
    assign sqw_en    = ctrl_q[3];

endmodule

// File: rtl/evt_irq_ctrl.sv
// Top of the periodic and event interrupt controller: joins the register
// file, tick divider and flag unit. Assumes tick_32k is a one-cycle strobe
// synchronous to clk and that event inputs are one-cycle pulses.
module evt_irq_ctrl
    import eic_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_32k,
    input  logic       alarm_in,
    input  logic       update_in,
    input  logic       supply_ok,
    input  logic [1:0] reg_addr,
    input  logic       wr_stb,
    input  logic       rd_stb,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       irq_req,
    output logic       sqw_out
);

    logic [2:0]         tb_sel;
    logic [3:0]         rate_code;
    logic [NUM_EVT-1:0] irq_en;
    logic               sqw_en;
    logic               flag_clr;
    logic               periodic_evt;
    logic [NUM_EVT-1:0] evt_vec;
    logic [NUM_EVT-1:0] flags_q;

    // Pack the three event sources into flag order.
    always_comb begin
        evt_vec         = '0;
        evt_vec[EV_PER] = periodic_evt;
        evt_vec[EV_ALM] = alarm_in;
        evt_vec[EV_UPD] = update_in;
    end

    eic_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .wr_stb    (wr_stb),
        .rd_stb    (rd_stb),
        .wr_data   (wr_data),
        .flags     (flags_q),
        .irq       (irq_req),
        .supply_ok (supply_ok),
        .tb_sel    (tb_sel),
        .rate_code (rate_code),
        .irq_en    (irq_en),
        .sqw_en    (sqw_en),
        .flag_clr  (flag_clr),
        .rd_data   (rd_data)
    );

    eic_rate_div #(.CNT_W(CNT_W)) u_div (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick_32k),
        .tb_sel       (tb_sel),
        .rate_code    (rate_code),
        .sqw_en       (sqw_en),
        .periodic_evt (periodic_evt),
        .sqw          (sqw_out)
    );

    eic_flag_unit u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_in  (evt_vec),
        .clr     (flag_clr),
        .en      (irq_en),
        .flags_q (flags_q),
        .irq     (irq_req)
    );

endmodule

// File: rtl/eic_checker.sv
// Property checker for evt_irq_ctrl, attached by bind below.
module eic_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_32k,
    input logic       alarm_in,
    input logic       update_in,
    input logic [1:0] reg_addr,
    input logic       rd_stb,
    input logic [7:0] rd_data,
    input logic       irq_req,
    input logic       sqw_out,
    input logic [2:0] tb_sel,
    input logic [3:0] rate_code,
    input logic       sqw_en,
    input logic [2:0] flags_q,
    input logic       periodic_evt
);

    p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data));

    p_evt_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        periodic_evt |-> (tick_32k && rate_code != 4'd0));

    p_tb_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tb_sel != 3'b010) |-> !periodic_evt);

    p_alarm_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_in |=> flags_q[1]);

    p_update_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        update_in |=> flags_q[0]);

    p_irq_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (flags_q != 3'b000));

    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && reg_addr == 2'd2 && !alarm_in && !update_in && !periodic_evt)
        |=> (flags_q == 3'b000 && !irq_req));

    p_sqw_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sqw_en |-> !sqw_out);

endmodule

bind evt_irq_ctrl eic_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_32k     (tick_32k),
    .alarm_in     (alarm_in),
    .update_in    (update_in),
    .reg_addr     (reg_addr),
    .rd_stb       (rd_stb),
    .rd_data      (rd_data),
    .irq_req      (irq_req),
    .sqw_out      (sqw_out),
    .tb_sel       (tb_sel),
    .rate_code    (rate_code),
    .sqw_en       (sqw_en),
    .flags_q      (flags_q),
    .periodic_evt (periodic_evt)
);

// File: tb/evt_irq_ctrl_tb.sv
module evt_irq_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_32k = 1'b0;
    logic       alarm_in = 1'b0;
    logic       update_in = 1'b0;
    logic       supply_ok = 1'b1;
    logic [1:0] reg_addr = 2'd0;
    logic       wr_stb = 1'b0;
    logic       rd_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       irq_req;
    logic       sqw_out;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    evt_irq_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_32k  (tick_32k),
        .alarm_in  (alarm_in),
        .update_in (update_in),
        .supply_ok (supply_ok),
        .reg_addr  (reg_addr),
        .wr_stb    (wr_stb),
        .rd_stb    (rd_stb),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .irq_req   (irq_req),
        .sqw_out   (sqw_out)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; wr_data = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        d = rd_data;
    endtask

    task automatic pulse_alarm();
        @(negedge clk); alarm_in = 1'b1;
        @(negedge clk); alarm_in = 1'b0;
    endtask

    task automatic pulse_update();
        @(negedge clk); update_in = 1'b1;
        @(negedge clk); update_in = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        chk(irq_req == 1'b0, "R1 irq", int'(irq_req), 0);
        chk(sqw_out == 1'b0, "R1 sqw", int'(sqw_out), 0);
        rd(2'd0, v); chk(v == 8'h26, "R1 rate reg", v, 8'h26);
        rd(2'd1, v); chk(v == 8'h00, "R1 ctrl reg", v, 8'h00);
        rd(2'd2, v); chk(v == 8'h00, "R1 flag reg", v, 8'h00);

        // R2 register access
        wr(2'd0, 8'hFF); rd(2'd0, v); chk(v == 8'h7F, "R2 rate bit7", v, 8'h7F);
        wr(2'd1, 8'hA5); rd(2'd1, v); chk(v == 8'hA5, "R2 ctrl rw", v, 8'hA5);
        wr(2'd2, 8'hFF); rd(2'd2, v); chk(v == 8'h00, "R2 flag write ignored", v, 8'h00);
        wr(2'd3, 8'h7F); rd(2'd3, v); chk(v == 8'h80, "R2 supply write ignored", v, 8'h80);
        rd(2'd1, v);
        repeat (3) @(negedge clk);
        chk(rd_data == 8'hA5, "R2 rd hold", rd_data, 8'hA5);
        wr(2'd0, 8'h20);
        wr(2'd1, 8'h00);

        // R8 supply status
        supply_ok = 1'b0;
        rd(2'd3, v); chk(v == 8'h00, "R8 supply lost", v, 8'h00);
        supply_ok = 1'b1;
        rd(2'd3, v); chk(v == 8'h80, "R8 supply ok", v, 8'h80);

        // R5 flags set without enables
        pulse_alarm();
        chk(irq_req == 1'b0, "R5 alarm masked irq", int'(irq_req), 0);
        rd(2'd2, v); chk(v == 8'h20, "R5 alarm flag", v, 8'h20);
        rd(2'd2, v); chk(v == 8'h00, "R7 cleared", v, 8'h00);
        pulse_update();
        rd(2'd2, v); chk(v == 8'h10, "R5 update flag", v, 8'h10);

        // R6 enabled request, R7 clear on read
        wr(2'd1, 8'h10);
        pulse_update();
        chk(irq_req == 1'b1, "R6 update irq", int'(irq_req), 1);
        rd(2'd2, v); chk(v == 8'h90, "R6 flag summary", v, 8'h90);
        chk(irq_req == 1'b0, "R7 irq dropped", int'(irq_req), 0);
        wr(2'd1, 8'h00);
        pulse_alarm();
        chk(irq_req == 1'b0, "R6 no enable", int'(irq_req), 0);
        wr(2'd1, 8'h20);
        chk(irq_req == 1'b1, "R6 late enable", int'(irq_req), 1);
        rd(2'd2, v); chk(v == 8'hA0, "R6 late enable value", v, 8'hA0);
        chk(irq_req == 1'b0, "R7 irq after read", int'(irq_req), 0);

        // R7 event colliding with read
        @(negedge clk);
        reg_addr = 2'd2; rd_stb = 1'b1; alarm_in = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0; alarm_in = 1'b0;
        chk(rd_data == 8'h00, "R7 collision value", rd_data, 8'h00);
        chk(irq_req == 1'b1, "R7 collision kept", int'(irq_req), 1);
        rd(2'd2, v); chk(v == 8'hA0, "R7 collision next read", v, 8'hA0);

        // R4 time base gate
        tick_32k = 1'b1;
        wr(2'd1, 8'h48);
        wr(2'd0, 8'h33);
        repeat (50) @(negedge clk);
        chk(sqw_out == 1'b0, "R4 sqw halted", int'(sqw_out), 0);
        rd(2'd2, v); chk(v == 8'h00, "R4 no periodic", v, 8'h00);

        // R3 code zero
        wr(2'd0, 8'h20);
        repeat (300) @(negedge clk);
        chk(sqw_out == 1'b0, "R9 sqw off code0", int'(sqw_out), 0);
        rd(2'd2, v); chk(v == 8'h00, "R3 code0 none", v, 8'h00);

        // R5 periodic flag with enable clear
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h23);
        repeat (20) @(negedge clk);
        chk(irq_req == 1'b0, "R5 periodic masked", int'(irq_req), 0);
        rd(2'd2, v); chk(v == 8'h40, "R5 periodic flag", v, 8'h40);

        // R3/R4/R9 sweep of all codes from a parked divider
        wr(2'd1, 8'h48);
        for (int c = 1; c < 16; c++) begin
            int p;
            int n;
            bit got;
            logic s_lo;
            logic s_hi;
            p = (c == 1) ? 128 : (c == 2) ? 256 : (1 << (c - 1));
            wr(2'd0, 8'(c));
            rd(2'd2, v);
            wr(2'd0, 8'(8'h20 | c));
            n = 0; got = 1'b0; s_lo = 1'b1; s_hi = 1'b0;
            while (!got && n < 40000) begin
                @(negedge clk);
                n++;
                if (n == p / 2 - 1) s_lo = sqw_out;
                if (n == p / 2) s_hi = sqw_out;
                if (irq_req) got = 1'b1;
            end
            chk(n == p, $sformatf("R3 R4 period code %0d", c), n, p);
            chk(!s_lo && s_hi && !sqw_out, $sformatf("R9 sqw edges code %0d", c),
                int'({s_lo, s_hi, sqw_out}), 3'b010);
        end

        // R9 square wave disabled while periodic runs
        begin
            bit seen;
            seen = 1'b0;
            wr(2'd1, 8'h40);
            wr(2'd0, 8'h23);
            repeat (40) begin
                @(negedge clk);
                if (sqw_out) seen = 1'b1;
            end
            chk(!seen, "R9 sqw disabled", int'(seen), 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule